// File: doc/BRIEF.md
# Paired-Action GPIO Register Bank

This block controls a small group of general-purpose pins (one to eight, set by a parameter) through a single 32-bit register. Software never writes a pin level or a direction directly. Each pin owns two bit pairs of write-one commands. The pair in the low half moves the output latch down or up. The pair in the high half switches the output driver on or off. A zero in any command bit leaves its pin alone. One full-width store can therefore change any subset of pins without a read-modify-write, and several pins can change in the same write.

On read, the same bit positions carry status instead of commands: the output latch, the synchronized pin input, the driver-enable flag and its inverse. A toggle is a read of the latch bit followed by a write of a 1 to either the clear or the set position of that pair. Pin inputs pass through a two-flop synchronizer before they can be read.

The bus is a plain register port: address, write strobe, write data and combinational read data. The register is at the address given by a parameter. A write to any other address is dropped, and a read from any other address returns zero. The port has no back-pressure: every write is accepted in the cycle it is presented, and read data is valid in the same cycle as its address.

Top module: `gpio_pair_bank`

## Requirements
- R1: After reset, every output latch is low and every driver is disabled, so `pin_out` and `pin_oe` are all zero and every pin is an input.
- R2: A write to the register address with bit 2k = 1 and bit 2k+1 = 0 sets pin k's latch to 0 at the next clock edge. A write with bit 2k = 0 and bit 2k+1 = 1 sets it to 1. The latch drives `pin_out[k]`.
- R3: A write with bit 16+2k = 1 and bit 17+2k = 0 turns on the driver of pin k (`pin_oe[k]` = 1). A write with bit 16+2k = 0 and bit 17+2k = 1 turns it off.
- R4: In a write, a pair whose two bits are both 0 leaves its latch or driver unchanged. One write can change any mix of pins at once.
- R5: In a write, a pair whose two bits are both 1 has no effect on that latch or driver.
- R6: A read from the register address returns, for each pin k in use: bit 2k = output latch, bit 2k+1 = synchronized input, bit 16+2k = driver enabled, bit 17+2k = the inverse of bit 16+2k.
- R7: A change on `pin_in[k]` that is present at clock edge E appears in read bit 2k+1 after edge E+1. Before that, the old value is read.
- R8: For slots k >= NPINS, all four bits read as 0, and writes to them change nothing visible.
- R9: When the address does not match REG_ADDR, a write changes no latch and no driver, and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (command pairs) |
| bus_rdata | output | 32 | Read data (status, combinational) |
| pin_in | input | NPINS | Raw pin levels from the pads |
| pin_out | output | NPINS | Output latch per pin |
| pin_oe | output | NPINS | Driver enable per pin |

## Verification
The embedded properties check every cycle that a lone clear or set command moves the latch and the driver to the commanded value, that a pair written as 00 or 11 leaves the state stable, that the synchronized input equals the raw input from two edges earlier, and that the mode bit and its inverse never agree. Only the bench scenarios can show the address decode, the zero read-back of unused slots, the multi-pin writes and the toggle idiom. This is done against a model of the register updated from random and directed bus traffic.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int REG_W     = 32;
  localparam int HALF_W    = REG_W / 2;
  localparam int MAX_PINS  = HALF_W / 2;

  typedef struct packed {
    logic lo_cmd;   // drive latch low
    logic hi_cmd;   // drive latch high
    logic en_cmd;   // driver on
    logic dis_cmd;  // driver off
  } pin_cmd_t;

  function automatic pin_cmd_t extract_cmd(input logic [REG_W-1:0] w, input int k);
    pin_cmd_t c;
    c.lo_cmd  = w[2*k];
    c.hi_cmd  = w[2*k+1];
    c.en_cmd  = w[HALF_W+2*k];
    c.dis_cmd = w[HALF_W+2*k+1];
    return c;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q, stage2_q;
  logic [1:0]   fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      fill_q   <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end
  end

  assign dout = stage2_q;

  // R7: two-edge latency once the pipe has filled
  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_pair_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  pin_cmd_t cmd,
  output logic     lat_q,
  output logic     oe_q
);
  logic lat_d, oe_d;

  always_comb begin
    lat_d = lat_q;
    oe_d  = oe_q;
    if (cmd_valid) begin
      if (cmd.lo_cmd && !cmd.hi_cmd) lat_d = 1'b0;
      if (cmd.hi_cmd && !cmd.lo_cmd) lat_d = 1'b1;
      if (cmd.en_cmd && !cmd.dis_cmd) oe_d = 1'b1;
      if (cmd.dis_cmd && !cmd.en_cmd) oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      lat_q <= lat_d;
      oe_q  <= oe_d;
    end
  end

  p_lat_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd.lo_cmd && !cmd.hi_cmd) |=> !lat_q);
  p_lat_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd.hi_cmd && !cmd.lo_cmd) |=> lat_q);
  p_drv_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd.en_cmd && !cmd.dis_cmd) |=> oe_q);
  p_drv_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd.dis_cmd && !cmd.en_cmd) |=> !oe_q);
  // R4 and R5: idle or conflicting pair keeps the latch
  p_lat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || (cmd.lo_cmd == cmd.hi_cmd)) |=> $stable(lat_q));
  p_drv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || (cmd.en_cmd == cmd.dis_cmd)) |=> $stable(oe_q));
endmodule

// File: rtl/gpio_rd_pack.sv
module gpio_rd_pack
  import gpio_pair_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             sel,
  input  logic [NPINS-1:0] lat,
  input  logic [NPINS-1:0] sync_in,
  input  logic [NPINS-1:0] oe,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] packed_w;

  for (genvar k = 0; k < MAX_PINS; k++) begin : g_slot
    if (k < NPINS) begin : g_used
      assign packed_w[2*k]          = lat[k];
      assign packed_w[2*k+1]        = sync_in[k];
      assign packed_w[HALF_W+2*k]   = oe[k];
      assign packed_w[HALF_W+2*k+1] = ~oe[k];
    end else begin : g_idle
      assign packed_w[2*k]          = 1'b0;
      assign packed_w[2*k+1]        = 1'b0;
      assign packed_w[HALF_W+2*k]   = 1'b0;
      assign packed_w[HALF_W+2*k+1] = 1'b0;
    end
  end

  assign rdata = sel ? packed_w : '0;
endmodule

// File: rtl/gpio_pair_bank.sv
module gpio_pair_bank
  import gpio_pair_pkg::*;
#(
  parameter int          NPINS    = 6,
  parameter int          AW       = 4,
  parameter logic [AW-1:0] REG_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  logic             hit;
  logic             wr_hit;
  logic [NPINS-1:0] sync_q;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_we && hit;

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (sync_q)
  );

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    gpio_pin_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (wr_hit),
      .cmd       (extract_cmd(bus_wdata, k)),
      .lat_q     (pin_out[k]),
      .oe_q      (pin_oe[k])
    );

    // R6: the mode bit and its inverse never agree on a register read
    p_mode_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (bus_rdata[HALF_W+2*k] != bus_rdata[HALF_W+2*k+1]));
  end

  gpio_rd_pack #(.NPINS(NPINS)) u_rd (
    .sel     (hit),
    .lat     (pin_out),
    .sync_in (sync_q),
    .oe      (pin_oe),
    .rdata   (bus_rdata)
  );

  // R9: writes elsewhere leave all pin state alone
  p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> ($stable(pin_out) && $stable(pin_oe)));
  // R1: state right after reset
  p_reset_state_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (pin_out == '0 && pin_oe == '0));
endmodule

// File: tb/gpio_pair_bank_test.sv
`timescale 1ns/1ps
module gpio_pair_bank_test;
  localparam int NP = 6;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [NP-1:0] m_lat, m_oe, m_s1, m_s2;

  always #5 clk = ~clk;

  gpio_pair_bank #(.NPINS(NP), .AW(AW), .REG_ADDR('0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (a != '0) return r;
    for (int k = 0; k < NP; k++) begin
      r[2*k]      = m_lat[k];
      r[2*k+1]    = m_s2[k];
      r[16+2*k]   = m_oe[k];
      r[17+2*k]   = ~m_oe[k];
    end
    return r;
  endfunction

  task automatic model_edge(input logic we, input logic [AW-1:0] a,
                            input logic [31:0] w, input logic [NP-1:0] p);
    if (we && a == '0) begin
      for (int k = 0; k < NP; k++) begin
        if (w[2*k] && !w[2*k+1]) m_lat[k] = 1'b0;
        if (w[2*k+1] && !w[2*k]) m_lat[k] = 1'b1;
        if (w[16+2*k] && !w[17+2*k]) m_oe[k] = 1'b1;
        if (w[17+2*k] && !w[16+2*k]) m_oe[k] = 1'b0;
      end
    end
    m_s2 = m_s1;
    m_s1 = p;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] er = exp_read(bus_addr);
    vectors++;
    if (bus_rdata !== er || pin_out !== m_lat || pin_oe !== m_oe) begin
      errors++;
      $display("FAIL %s: rdata=%h out=%b oe=%b expected rdata=%h out=%b oe=%b",
               tag, bus_rdata, pin_out, pin_oe, er, m_lat, m_oe);
    end
  endtask

  // drive at negedge, clock once, update model, check at next negedge
  task automatic step(input logic we, input logic [AW-1:0] a,
                      input logic [31:0] w, input logic [NP-1:0] p,
                      input string tag);
    bus_we = we; bus_addr = a; bus_wdata = w; pin_in = p;
    @(posedge clk);
    model_edge(we, a, w, p);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
    #1;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, pin_in, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    m_lat = '0; m_oe = '0; m_s1 = '0; m_s2 = '0;
    repeat (3) @(negedge clk);
    pin_in = 6'b101010;
    @(negedge clk);
    #1;
    check_all("R1 reset");
    rst_n = 1'b1;

    // R2/R3: pin 2 high and driving
    step(1'b1, '0, (32'h2 << 4) | (32'h1 << 20), 6'b101010, "R2 R3 set+enable pin2");
    // R7: input change visible only after the second edge
    step(1'b0, '0, '0, 6'b010101, "R7 first edge old input");
    step(1'b0, '0, '0, 6'b010101, "R7 second edge new input");
    // R2: clear pin 2, R3 disable
    step(1'b1, '0, (32'h1 << 4) | (32'h2 << 20), 6'b010101, "R2 R3 clear+disable pin2");
    // R4: several pins at once, others untouched
    step(1'b1, '0, 32'h0000_0A02 | 32'h0015_0000, 6'b010101, "R4 multi-pin write");
    step(1'b1, '0, 32'h0000_0000, 6'b010101, "R4 all-zero write");
    // R5: both bits of a pair set
    step(1'b1, '0, 32'h0000_0003 | 32'h0003_0000, 6'b010101, "R5 conflict pin0");
    step(1'b1, '0, 32'hFFFF_FFFF, 6'b010101, "R5 conflict all pairs");
    // R8: slots 6 and 7 are unused
    step(1'b1, '0, 32'hA000_A000, 6'b010101, "R8 unused slot write");
    step(1'b1, '0, 32'h5000_5000, 6'b010101, "R8 unused slot write 2");
    // R9: wrong address write and read
    step(1'b1, 4'h3, 32'h0000_0AAA | 32'h0555_0000, 6'b111111, "R9 miss write");
    bus_addr = 4'h5; #1; check_all("R9 miss read");
    bus_addr = '0;   #1; check_all("R6 register read");
    // toggle idiom on pin 1 (R2, R6)
    for (int t = 0; t < 4; t++) begin
      logic [31:0] rd;
      bus_addr = '0; #1; rd = bus_rdata;
      step(1'b1, '0, rd[2] ? (32'h1 << 2) : (32'h2 << 2), pin_in, "R2 R6 toggle");
    end

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w = $urandom;
      logic        we = ($urandom % 4) != 0;
      logic [AW-1:0] a = (($urandom % 5) == 0) ? AW'($urandom) : '0;
      logic [NP-1:0] p = NP'($urandom);
      step(we, a, w, p, "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    idle("R6 final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule